// File: doc/BRIEF.md
# Byte-to-Gray Line Burst Repacker

This block sits in front of an edge-detection pipeline and behind a byte-wide receiver. The receiver delivers bytes with an irregular valid strobe, three bytes per pixel. The block groups the bytes into pixels, keeps the last byte of each group as the pixel's gray value, and stores the gray values in a small line memory. Once a full line of gray values has been stored, the block plays that line out on consecutive clock cycles. The edge detector downstream therefore sees a valid that stays high, without gaps, for exactly one line.

The memory holds several line slots. A new line can be filled while an earlier one is still being played out. If a pixel completes while every slot is still occupied, that pixel is dropped and a sticky overflow flag rises. The processed gray value that comes back from the edge detector is widened into a 32-bit word: a zero top byte, then the gray byte repeated in the three lower lanes.

Top module: `gray_line_repacker`

## Requirements
- R1: A modulo-3 byte counter advances only on `in_valid`. The third byte of each group is the pixel's gray value, and the first two bytes of the group never appear on `burst_pix`.
- R2: Cycles with `in_valid` low do not advance the byte grouping, so any pattern of idle gaps between bytes gives the same pixel values.
- R3: No burst starts until all LINE_LEN pixels of a line have been stored. A line with LINE_LEN-1 pixels produces no `burst_valid`.
- R4: A burst holds `burst_valid` high for exactly LINE_LEN consecutive cycles and then drops it. `burst_pix` presents the line's gray values in the order they were written.
- R5: With the default two line slots, lines that arrive back to back at full byte rate are all played out intact, one burst per line, and `overflow` stays 0.
- R6: A pixel that completes while all line slots are occupied is discarded and never appears in a later burst. `overflow` then goes to 1 and stays at 1 until reset.
- R7: One cycle after `proc_valid` is high with value p, `word_out` = {8'h00, p, p, p} and `word_valid` = 1. One cycle after `proc_valid` is low, `word_valid` = 0.
- R8: The active-low asynchronous reset clears all outputs to 0, clears any partly received pixel, and returns the burst logic to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_byte | input | 8 | Received byte |
| in_valid | input | 1 | `in_byte` is valid this cycle |
| burst_pix | output | 8 | Gray value being played out |
| burst_valid | output | 1 | High without gaps for one line per burst |
| proc_pix | input | 8 | Processed gray value from the edge detector |
| proc_valid | input | 1 | `proc_pix` is valid |
| word_out | output | 32 | Packed word: zero byte plus three gray lanes |
| word_valid | output | 1 | `word_out` is valid |
| overflow | output | 1 | Sticky flag: a pixel was dropped because all slots were full |

## Verification
The hardest case to reach is overflow. With two slots, a line is played out in LINE_LEN cycles, but filling a line takes at least 3·LINE_LEN cycles, so the ports alone can never fill both slots. The bench therefore also builds the block with a single slot. It sends one full line at full byte rate and then one more pixel at once. That extra pixel completes while the only slot is still being read, so it is dropped. The bench then checks that the next full line plays out without the dropped value.

// File: rtl/repack_pkg.sv
package repack_pkg;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

    function automatic logic [31:0] gray_to_word(input logic [7:0] g);
        return {8'h00, g, g, g};
    endfunction

endpackage

// File: rtl/byte_assembler.sv
module byte_assembler #(
    parameter int PIX_BYTES = 3,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              pix_rdy,
    output logic [BYTE_W-1:0] pix_gray
);
    localparam int CNT_W = $clog2(PIX_BYTES);
    localparam int SH_W  = PIX_BYTES * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0]  sh;
        logic             rdy;
    } asm_t;

    asm_t q, d;

    always_comb begin
        d     = q;
        d.rdy = 1'b0;
        if (in_valid) begin
            d.sh = {q.sh[SH_W-BYTE_W-1:0], in_byte};
            if (q.cnt == CNT_W'(PIX_BYTES - 1)) begin
                d.cnt = '0;
                d.rdy = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pix_rdy  = q.rdy;
    assign pix_gray = q.sh[BYTE_W-1:0];

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(PIX_BYTES - 1)); // R1
    AST_PIX_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rdy |=> !pix_rdy); // R1

endmodule

// File: rtl/line_store.sv
module line_store #(
    parameter int LINE_LEN  = 1024,
    parameter int NUM_LINES = 2,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              burst_start,
    input  logic              burst_end,
    input  logic              rd_en,
    input  logic [((NUM_LINES > 1) ? $clog2(NUM_LINES) : 1)-1:0] rd_line,
    input  logic [$clog2(LINE_LEN)-1:0] rd_col,
    output logic [BYTE_W-1:0] rd_data,
    output logic              pend_nz,
    output logic              overflow
);
    localparam int COL_W     = $clog2(LINE_LEN);
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int OCC_W     = $clog2(NUM_LINES + 1);
    localparam int ADDR_W    = LINE_W + COL_W;
    localparam int MEM_DEPTH = 2 ** ADDR_W;

    typedef struct packed {
        logic [COL_W-1:0]  wr_col;
        logic [LINE_W-1:0] wr_line;
        logic [OCC_W-1:0]  occ;
        logic [OCC_W-1:0]  pend;
        logic              ovf;
    } store_t;

    store_t q, d;
    logic   accept, line_done;
    logic [BYTE_W-1:0] mem [MEM_DEPTH];
    logic [BYTE_W-1:0] rd_data_q;

    always_comb begin
        d         = q;
        accept    = wr_en && (q.occ < OCC_W'(NUM_LINES));
        line_done = accept && (q.wr_col == COL_W'(LINE_LEN - 1));
        d.ovf     = q.ovf | (wr_en && !accept);
        if (accept) begin
            if (line_done) begin
                d.wr_col  = '0;
                d.wr_line = (q.wr_line == LINE_W'(NUM_LINES - 1)) ? '0 : q.wr_line + 1'b1;
            end else begin
                d.wr_col = q.wr_col + 1'b1;
            end
        end
        d.occ  = q.occ  + OCC_W'(line_done) - OCC_W'(burst_end);
        d.pend = q.pend + OCC_W'(line_done) - OCC_W'(burst_start);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[{q.wr_line, q.wr_col}] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data_q <= '0;
        else if (rd_en) rd_data_q <= mem[{rd_line, rd_col}];
    end

    assign rd_data  = rd_data_q;
    assign pend_nz  = (q.pend != '0);
    assign overflow = q.ovf;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R6
    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.occ == OCC_W'(NUM_LINES)) |=> $stable(q.wr_col)); // R6
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.occ <= OCC_W'(NUM_LINES)); // R5

endmodule

// File: rtl/burst_reader.sv
module burst_reader
    import repack_pkg::*;
#(
    parameter int LINE_LEN  = 1024,
    parameter int NUM_LINES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nz,
    output logic rd_en,
    output logic [((NUM_LINES > 1) ? $clog2(NUM_LINES) : 1)-1:0] rd_line,
    output logic [$clog2(LINE_LEN)-1:0] rd_col,
    output logic burst_start,
    output logic burst_end,
    output logic burst_valid
);
    localparam int COL_W  = $clog2(LINE_LEN);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    typedef struct packed {
        rd_state_e         st;
        logic [COL_W-1:0]  col;
        logic [LINE_W-1:0] line;
        logic              vld;
    } rd_t;

    rd_t q, d;

    always_comb begin
        d           = q;
        burst_start = 1'b0;
        burst_end   = 1'b0;
        d.vld       = (q.st == RD_RUN);
        case (q.st)
            RD_IDLE: begin
                if (pend_nz) begin
                    d.st        = RD_RUN;
                    d.col       = '0;
                    burst_start = 1'b1;
                end
            end
            default: begin
                if (q.col == COL_W'(LINE_LEN - 1)) begin
                    d.st      = RD_IDLE;
                    burst_end = 1'b1;
                    d.line    = (q.line == LINE_W'(NUM_LINES - 1)) ? '0 : q.line + 1'b1;
                end else begin
                    d.col = q.col + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_en       = (q.st == RD_RUN);
    assign rd_line     = q.line;
    assign rd_col      = q.col;
    assign burst_valid = q.vld;

    AST_BURST_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> $past(pend_nz)); // R3
    AST_BURST_LEN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_col == COL_W'(LINE_LEN - 1)) |=> !rd_en); // R4
    AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> burst_valid); // R4

endmodule

// File: rtl/word_packer.sv
module word_packer
    import repack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  proc_pix,
    input  logic        proc_valid,
    output logic [31:0] word_out,
    output logic        word_valid
);
    typedef struct packed {
        logic [31:0] word;
        logic        vld;
    } pack_t;

    pack_t q, d;

    always_comb begin
        d     = q;
        d.vld = proc_valid;
        if (proc_valid) d.word = gray_to_word(proc_pix);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_out   = q.word;
    assign word_valid = q.vld;

    AST_PACK_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        proc_valid |=> (word_valid && word_out[31:24] == 8'h00
                        && word_out[23:16] == word_out[7:0]
                        && word_out[15:8] == word_out[7:0])); // R7

endmodule

// File: rtl/gray_line_repacker.sv
module gray_line_repacker #(
    parameter int LINE_LEN  = 1024,
    parameter int NUM_LINES = 2,
    parameter int PIX_BYTES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  in_byte,
    input  logic        in_valid,
    output logic [7:0]  burst_pix,
    output logic        burst_valid,
    input  logic [7:0]  proc_pix,
    input  logic        proc_valid,
    output logic [31:0] word_out,
    output logic        word_valid,
    output logic        overflow
);
    localparam int COL_W  = $clog2(LINE_LEN);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic              pix_rdy;
    logic [7:0]        pix_gray;
    logic              pend_nz, rd_en, burst_start, burst_end;
    logic [LINE_W-1:0] rd_line;
    logic [COL_W-1:0]  rd_col;

    byte_assembler #(.PIX_BYTES(PIX_BYTES), .BYTE_W(8)) u_asm (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .pix_rdy(pix_rdy), .pix_gray(pix_gray)
    );

    line_store #(.LINE_LEN(LINE_LEN), .NUM_LINES(NUM_LINES), .BYTE_W(8)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(pix_rdy), .wr_data(pix_gray),
        .burst_start(burst_start), .burst_end(burst_end), .rd_en(rd_en),
        .rd_line(rd_line), .rd_col(rd_col), .rd_data(burst_pix),
        .pend_nz(pend_nz), .overflow(overflow)
    );

    burst_reader #(.LINE_LEN(LINE_LEN), .NUM_LINES(NUM_LINES)) u_rd (
        .clk(clk), .rst_n(rst_n), .pend_nz(pend_nz), .rd_en(rd_en),
        .rd_line(rd_line), .rd_col(rd_col), .burst_start(burst_start),
        .burst_end(burst_end), .burst_valid(burst_valid)
    );

    word_packer u_pack (
        .clk(clk), .rst_n(rst_n), .proc_pix(proc_pix), .proc_valid(proc_valid),
        .word_out(word_out), .word_valid(word_valid)
    );

endmodule

// File: tb/gray_line_repacker_bench.sv
module gray_line_repacker_bench;
    localparam int LEN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  proc_pix = '0;
    logic        proc_valid = 1'b0;
    logic [7:0]  burst_pix, burst_pix1;
    logic        burst_valid, burst_valid1;
    logic [31:0] word_out, word_out1;
    logic        word_valid, word_valid1;
    logic        overflow, overflow1;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    gray_line_repacker #(.LINE_LEN(LEN), .NUM_LINES(2)) u_gray_line_repacker (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .burst_pix(burst_pix), .burst_valid(burst_valid), .proc_pix(proc_pix),
        .proc_valid(proc_valid), .word_out(word_out), .word_valid(word_valid),
        .overflow(overflow)
    );

    gray_line_repacker #(.LINE_LEN(LEN), .NUM_LINES(1)) u_gray_line_repacker_one (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .burst_pix(burst_pix1), .burst_valid(burst_valid1), .proc_pix(proc_pix),
        .proc_valid(proc_valid), .word_out(word_out1), .word_valid(word_valid1),
        .overflow(overflow1)
    );

    // burst monitors, sampled at the falling edge
    logic [7:0] cap  [0:63];
    logic [7:0] cap1 [0:63];
    int ncap, nrun, run, ncap1;
    int runs [0:7];

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            ncap = 0; nrun = 0; run = 0; ncap1 = 0;
        end else begin
            if (burst_valid) begin
                if (ncap < 64) cap[ncap] = burst_pix;
                ncap++; run++;
            end else if (run > 0) begin
                if (nrun < 8) runs[nrun] = run;
                nrun++; run = 0;
            end
            if (burst_valid1) begin
                if (ncap1 < 64) cap1[ncap1] = burst_pix1;
                ncap1++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        in_valid = 0; proc_valid = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        @(negedge clk);
        in_byte = b; in_valid = 1;
        if (gap > 0) begin
            @(negedge clk);
            in_valid = 0;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic send_pixel(input logic [7:0] g, input int gap);
        send_byte(~g, gap);
        send_byte(g ^ 8'h5a, gap);
        send_byte(g, gap);
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        in_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        apply_reset();
        check(burst_valid == 0 && burst_pix == 0, "R8 burst after reset", {burst_valid, burst_pix}, 0);
        check(word_valid == 0 && word_out == 0, "R8 word after reset", word_out, 0);
        check(overflow == 0, "R8 overflow after reset", overflow, 0);
    endtask

    task automatic t_sparse();
        apply_reset();
        for (int i = 0; i < LEN; i++) send_pixel(8'h10 + 8'(i), i % 3);
        go_idle(40);
        check(ncap == LEN, "R1 R2 pixel count", ncap, LEN);
        check(nrun == 1 && runs[0] == LEN, "R4 burst length", runs[0], LEN);
        for (int i = 0; i < LEN; i++)
            check(cap[i] == 8'h10 + 8'(i), "R1 R2 gray value", cap[i], 8'h10 + i);
    endtask

    task automatic t_partial();
        apply_reset();
        for (int i = 0; i < LEN - 1; i++) send_pixel(8'h80 + 8'(i), 0);
        go_idle(40);
        check(ncap == 0, "R3 no burst on partial line", ncap, 0);
        send_pixel(8'hC3, 1);
        go_idle(40);
        check(ncap == LEN, "R3 burst after last pixel", ncap, LEN);
        check(cap[LEN-1] == 8'hC3, "R4 last pixel order", cap[LEN-1], 8'hC3);
    endtask

    task automatic t_back_to_back();
        apply_reset();
        for (int i = 0; i < 2 * LEN; i++) send_pixel(8'(3 * i + 1), 0);
        go_idle(40);
        check(ncap == 2 * LEN, "R5 two lines out", ncap, 2 * LEN);
        check(nrun == 2 && runs[0] == LEN && runs[1] == LEN, "R4 R5 two bursts", nrun, 2);
        for (int i = 0; i < 2 * LEN; i++)
            check(cap[i] == 8'(3 * i + 1), "R5 line data", cap[i], 3 * i + 1);
        check(overflow == 0, "R5 no overflow with two slots", overflow, 0);
    endtask

    task automatic t_overflow();
        apply_reset();
        for (int i = 0; i < LEN; i++) send_pixel(8'h20 + 8'(i), 0);
        send_pixel(8'hEE, 0);
        go_idle(2);
        check(overflow1 == 1, "R6 overflow raised", overflow1, 1);
        go_idle(40);
        check(overflow1 == 1, "R6 overflow sticky", overflow1, 1);
        for (int i = 0; i < LEN; i++) send_pixel(8'h40 + 8'(i), 0);
        go_idle(40);
        check(ncap1 == 2 * LEN, "R6 two bursts single slot", ncap1, 2 * LEN);
        for (int i = 0; i < LEN; i++)
            check(cap1[LEN + i] == 8'h40 + 8'(i), "R6 dropped pixel absent", cap1[LEN + i], 8'h40 + i);
        check(overflow == 0, "R5 two-slot no overflow", overflow, 0);
    endtask

    task automatic t_mid_reset();
        apply_reset();
        send_byte(8'h99, 0);
        send_byte(8'h98, 0);
        @(negedge clk);
        in_valid = 0;
        #2 rst_n = 0;
        #3 check(burst_valid == 0 && overflow == 0, "R8 async reset outputs", burst_valid, 0);
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < LEN; i++) send_pixel(8'hA0 + 8'(i), 0);
        go_idle(40);
        check(ncap == LEN, "R8 count after reset", ncap, LEN);
        check(cap[0] == 8'hA0 && cap[LEN-1] == 8'hA0 + 8'(LEN - 1), "R8 grouping restarted", cap[0], 8'hA0);
    endtask

    task automatic t_pack();
        logic [7:0] vals [0:2];
        vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'h5A;
        apply_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            proc_pix = vals[i]; proc_valid = 1;
            @(negedge clk);
            check(word_valid == 1 && word_out == {8'h00, vals[i], vals[i], vals[i]},
                  "R7 packed word", word_out, {8'h00, vals[i], vals[i], vals[i]});
        end
        proc_valid = 0; proc_pix = 8'h77;
        @(negedge clk);
        check(word_valid == 0, "R7 valid drops", word_valid, 0);
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sparse();
        t_partial();
        t_back_to_back();
        t_overflow();
        t_mid_reset();
        t_pack();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule